// File: doc/BRIEF.md
# Memory-Mapped Read-XOR-Write Transfer Engine

This peripheral copies one 32-bit word from one memory location to another and flips selected bits on the way. Software programs a source address, a mask word and a destination address through a small register port. It then writes the start bit in the control word. The engine becomes a bus master and issues one single-beat read. It XORs the returned word with the mask and issues one single-beat write. It then reports completion or failure through two sticky flags that share one level-sensitive interrupt line.

Byte order follows the order of the bytes on the wire. The byte at the lowest address travels on bits 31:24 of the master data bus, and that byte is combined with mask bits 31:24. The byte at address+3 travels on bits 7:0 and is combined with mask bits 7:0. The addresses and the mask are captured when the transfer leaves idle. Software may rewrite the registers during a transfer without disturbing it.

Top module: `xor_dma_engine`

## Requirements
- R1: Offsets 0x0 (source address), 0x4 (mask) and 0x8 (destination address) hold full 32-bit values that read back as written. After reset, every register reads 0, the interrupt is low and no master request is active.
- R2: An access whose byte enables are not 4'hF, or whose offset has bits 1:0 non-zero, is answered with regErr high in the same cycle. It reads 0 and changes no register.
- R3: The control word sits at offset 0xC. Bit 0 is START (write 1 to set), bit 1 is DONE and bit 2 is ERROR (each is set by hardware and cleared by writing 1). Writing 0 to a bit leaves that bit unchanged.
- R4: After START, the engine issues exactly one read at the captured source address. It then issues exactly one write at the captured destination address, with data equal to the read word XOR the captured mask. The byte at address+0 occupies bits 31:24.
- R5: When the write is acknowledged without error, DONE sets and ERROR stays clear.
- R6: If the read returns an error, ERROR sets, DONE stays clear and no write is issued.
- R7: If the write returns an error, ERROR sets and DONE stays clear.
- R8: The irq output is high exactly while DONE or ERROR is set. It falls in the cycle after the write that clears the last of them.
- R9: START reads 1 from the accepted write until the transfer ends. A START written during that time is ignored and causes no second transfer.
- R10: An accepted START clears any DONE and ERROR left over from an earlier transfer.
- R11: Once raised, dmaReq holds its address, write enable and data stable until dmaAck or dmaErr is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Byte offset within the register window |
| regByteEn | input | 4 | Byte enables of the register access |
| regWrite | input | 1 | Register write strobe |
| regRead | input | 1 | Register read strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, valid in the cycle of regRead |
| regErr | output | 1 | Alignment error response, same cycle |
| dmaReq | output | 1 | Master request, held until acknowledged or errored |
| dmaWe | output | 1 | Master request is a write |
| dmaAddr | output | 32 | Master byte address |
| dmaWdata | output | 32 | Master write data, byte at address+0 on bits 31:24 |
| dmaRdata | input | 32 | Master read data, valid with dmaAck |
| dmaAck | input | 1 | Master transfer completed |
| dmaErr | input | 1 | Master transfer failed |
| irq | output | 1 | Level interrupt, DONE or ERROR |

## Verification
Register reads and the error response come back in the same cycle as the strobe, so the bench samples them a quarter period after driving. Register writes take effect at the next edge. A START accepted at edge N reads back as busy right after that edge. The read request rises at edge N+1. Each memory response, given at a chosen latency, moves the engine on at the following edge. DONE or ERROR, and irq with them, appear one edge after the final response. The bench therefore waits for irq with a bounded poll, then reads the flags and the bench memory. The memory model counts read and write requests and records whether any request changed its address while it was waiting.

// File: rtl/xdma_pkg.sv
package xdma_pkg;
  localparam int OFF_W = 4;
  localparam logic [OFF_W-1:0] OFF_SRC  = 4'h0;
  localparam logic [OFF_W-1:0] OFF_MASK = 4'h4;
  localparam logic [OFF_W-1:0] OFF_DEST = 4'h8;
  localparam logic [OFF_W-1:0] OFF_CTRL = 4'hC;
  localparam int BIT_START = 0;
  localparam int BIT_DONE  = 1;
  localparam int BIT_ERROR = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE
  } xferState_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic takeStart;  // leaving idle: capture operands, drop pending start
    logic latchRead;  // read data arrived: store XORed word
    logic setDone;
    logic setError;
  } xdmaStrobe_t;
endpackage

// File: rtl/xdma_datapath.sv
module xdma_datapath
  import xdma_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OFF_W-1:0]  regAddr,
  input  logic [DATA_W/8-1:0] regByteEn,
  input  logic              regWrite,
  input  logic              regRead,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              regErr,
  input  xdmaStrobe_t       strobe,
  input  logic              busy,
  input  logic              dmaWe,
  input  logic [DATA_W-1:0] dmaRdata,
  output logic [DATA_W-1:0] dmaAddr,
  output logic [DATA_W-1:0] dmaWdata,
  output logic              startPend,
  output logic              irq
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] srcReg, maskReg, destReg;
  logic [DATA_W-1:0] xferSrc, xferMask, xferDest, resultReg;
  logic [DATA_W-1:0] xored;
  logic doneFlag, errorFlag;
  logic legal, wrOk, wrCtrl, startAccept;

  assign legal       = (regByteEn == '1) && (regAddr[1:0] == 2'b00);
  assign regErr      = (regWrite || regRead) && !legal;
  assign wrOk        = regWrite && legal;
  assign wrCtrl      = wrOk && (regAddr == OFF_CTRL);
  assign startAccept = wrCtrl && regWdata[BIT_START] && !busy && !startPend;

  // lane i carries the byte at address+i, most significant lane first
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int HI = DATA_W - 1 - 8 * i;
    assign xored[HI -: 8] = dmaRdata[HI -: 8] ^ xferMask[HI -: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcReg  <= '0;
      maskReg <= '0;
      destReg <= '0;
    end else if (wrOk) begin
      if (regAddr == OFF_SRC)  srcReg  <= regWdata;
      if (regAddr == OFF_MASK) maskReg <= regWdata;
      if (regAddr == OFF_DEST) destReg <= regWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xferSrc   <= '0;
      xferMask  <= '0;
      xferDest  <= '0;
      resultReg <= '0;
    end else begin
      if (strobe.takeStart) begin
        xferSrc  <= srcReg;
        xferMask <= maskReg;
        xferDest <= destReg;
      end
      if (strobe.latchRead) resultReg <= xored;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startPend <= 1'b0;
      doneFlag  <= 1'b0;
      errorFlag <= 1'b0;
    end else begin
      if (strobe.takeStart) startPend <= 1'b0;
      else if (startAccept) startPend <= 1'b1;

      if (strobe.setDone) doneFlag <= 1'b1;
      else if (startAccept) doneFlag <= 1'b0;
      else if (wrCtrl && regWdata[BIT_DONE]) doneFlag <= 1'b0;

      if (strobe.setError) errorFlag <= 1'b1;
      else if (startAccept) errorFlag <= 1'b0;
      else if (wrCtrl && regWdata[BIT_ERROR]) errorFlag <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regRead && legal) begin
      unique case (regAddr)
        OFF_SRC:  regRdata = srcReg;
        OFF_MASK: regRdata = maskReg;
        OFF_DEST: regRdata = destReg;
        default: begin
          regRdata[BIT_START] = startPend || busy;
          regRdata[BIT_DONE]  = doneFlag;
          regRdata[BIT_ERROR] = errorFlag;
        end
      endcase
    end
  end

  assign dmaAddr  = dmaWe ? xferDest : xferSrc;
  assign dmaWdata = resultReg;
  assign irq      = doneFlag || errorFlag;

  // R2: a rejected write leaves the programmed registers untouched
  assert_bad_write_no_change_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regErr) |=> ($stable(srcReg) && $stable(maskReg) && $stable(destReg)));

  // R8: the interrupt only drops after a register write
  assert_irq_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !regWrite) |=> irq);

  // R10: an accepted start leaves both flags clear
  assert_start_clears_flags_R10: assert property (@(posedge clk) disable iff (!rstN)
    startAccept |=> !irq);
endmodule

// File: rtl/xdma_ctrl.sv
module xdma_ctrl
  import xdma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPend,
  input  logic        dmaAck,
  input  logic        dmaErr,
  output logic        dmaReq,
  output logic        dmaWe,
  output logic        busy,
  output xdmaStrobe_t strobe
);
  xferState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (startPend) begin
        strobe.takeStart = 1'b1;
        stateNext = ST_READ;
      end
      ST_READ: if (dmaErr) begin
        strobe.setError = 1'b1;
        stateNext = ST_IDLE;
      end else if (dmaAck) begin
        strobe.latchRead = 1'b1;
        stateNext = ST_WRITE;
      end
      ST_WRITE: if (dmaErr) begin
        strobe.setError = 1'b1;
        stateNext = ST_IDLE;
      end else if (dmaAck) begin
        strobe.setDone = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign dmaReq = (state == ST_READ) || (state == ST_WRITE);
  assign dmaWe  = (state == ST_WRITE);
  assign busy   = (state != ST_IDLE);

  // R11: a pending request keeps its direction until answered
  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && !dmaAck && !dmaErr) |=> (dmaReq && $stable(dmaWe)));

  // R6: a failed read is never followed by a write
  assert_no_write_after_read_err_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && !dmaWe && dmaErr) |=> !dmaReq);

  // R5: at most one status outcome per cycle
  assert_single_outcome_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.setDone, strobe.setError, strobe.latchRead}));
endmodule

// File: rtl/xor_dma_engine.sv
module xor_dma_engine
  import xdma_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        regAddr,
  input  logic [3:0]        regByteEn,
  input  logic              regWrite,
  input  logic              regRead,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              regErr,
  output logic              dmaReq,
  output logic              dmaWe,
  output logic [31:0]       dmaAddr,
  output logic [31:0]       dmaWdata,
  input  logic [31:0]       dmaRdata,
  input  logic              dmaAck,
  input  logic              dmaErr,
  output logic              irq
);
  xdmaStrobe_t strobe;
  logic busy, startPend;

  xdma_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startPend(startPend),
    .dmaAck(dmaAck), .dmaErr(dmaErr),
    .dmaReq(dmaReq), .dmaWe(dmaWe), .busy(busy), .strobe(strobe)
  );

  xdma_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regByteEn(regByteEn), .regWrite(regWrite), .regRead(regRead),
    .regWdata(regWdata), .regRdata(regRdata), .regErr(regErr),
    .strobe(strobe), .busy(busy), .dmaWe(dmaWe), .dmaRdata(dmaRdata),
    .dmaAddr(dmaAddr), .dmaWdata(dmaWdata), .startPend(startPend), .irq(irq)
  );

  // R11: address and data hold while a request waits
  assert_addr_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && !dmaAck && !dmaErr) |=> ($stable(dmaAddr) && $stable(dmaWdata)));
endmodule

// File: tb/xor_dma_engine_tb.sv
module xor_dma_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] regAddr = '0;
  logic [3:0] regByteEn = '0;
  logic regWrite = 1'b0, regRead = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic regErr;
  logic dmaReq, dmaWe;
  logic [31:0] dmaAddr, dmaWdata;
  logic [31:0] dmaRdata = '0;
  logic dmaAck = 1'b0, dmaErr = 1'b0;
  logic irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  xor_dma_engine dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regByteEn(regByteEn),
    .regWrite(regWrite), .regRead(regRead), .regWdata(regWdata),
    .regRdata(regRdata), .regErr(regErr), .dmaReq(dmaReq), .dmaWe(dmaWe),
    .dmaAddr(dmaAddr), .dmaWdata(dmaWdata), .dmaRdata(dmaRdata),
    .dmaAck(dmaAck), .dmaErr(dmaErr), .irq(irq)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // memory model: 0x4000xxxx read/write, 0x6000xxxx read-only, rest unmapped
  logic [31:0] mem [16];
  int latency = 0, waitCnt = 0;
  int readReqs = 0, writeReqs = 0;
  logic [31:0] firstAddr;
  bit addrMoved = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      dmaAck = 0; dmaErr = 0; waitCnt = 0;
    end else if (dmaAck || dmaErr) begin
      dmaAck = 0; dmaErr = 0; waitCnt = 0;
    end else if (dmaReq) begin
      if (waitCnt == 0) firstAddr = dmaAddr;
      else if (dmaAddr !== firstAddr) addrMoved = 1;
      if (waitCnt < latency) waitCnt++;
      else if (dmaWe) begin
        writeReqs++;
        if (dmaAddr[31:16] == 16'h4000) begin
          mem[dmaAddr[5:2]] = dmaWdata; dmaAck = 1;
        end else dmaErr = 1;
      end else begin
        readReqs++;
        if (dmaAddr[31:16] == 16'h4000 || dmaAddr[31:16] == 16'h6000) begin
          dmaRdata = mem[dmaAddr[5:2]]; dmaAck = 1;
        end else dmaErr = 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regAcc(input bit wr, input logic [3:0] off, input logic [31:0] wd,
                        input logic [3:0] be, output logic [31:0] rd, output logic er);
    @(negedge clk);
    regAddr = off; regByteEn = be; regWdata = wd;
    regWrite = wr; regRead = !wr;
    #(CLK_PERIOD/4);
    rd = regRdata; er = regErr;
    @(negedge clk);
    regWrite = 0; regRead = 0;
  endtask

  task automatic wr32(input logic [3:0] off, input logic [31:0] wd);
    logic [31:0] rd; logic er;
    regAcc(1, off, wd, 4'hF, rd, er);
  endtask

  task automatic rd32(input logic [3:0] off, output logic [31:0] rd);
    logic er;
    regAcc(0, off, '0, 4'hF, rd, er);
  endtask

  task automatic waitIrq(input string tag);
    int n = 0;
    while (!irq && n < 200) begin @(negedge clk); n++; end
    check(irq, tag, {31'b0, irq}, 32'h1);
  endtask

  task automatic runXfer(input logic [31:0] src, input logic [31:0] mask, input logic [31:0] dst);
    wr32(4'h0, src); wr32(4'h4, mask); wr32(4'h8, dst);
    wr32(4'hC, 32'h1);
  endtask

  task automatic testReset();
    logic [31:0] rd;
    for (int i = 0; i < 4; i++) begin
      rd32(4'(i * 4), rd);
      check(rd == 0, "R1 reset value", rd, 0);
    end
    check(!irq && !dmaReq, "R1 reset irq/req", {30'b0, irq, dmaReq}, 0);
  endtask

  task automatic testRegs();
    logic [31:0] rd;
    wr32(4'h0, 32'h1234_5678); wr32(4'h4, 32'hA5A5_0F0F); wr32(4'h8, 32'hDEAD_BEEF);
    rd32(4'h0, rd); check(rd == 32'h1234_5678, "R1 source", rd, 32'h1234_5678);
    rd32(4'h4, rd); check(rd == 32'hA5A5_0F0F, "R1 mask", rd, 32'hA5A5_0F0F);
    rd32(4'h8, rd); check(rd == 32'hDEAD_BEEF, "R1 dest", rd, 32'hDEAD_BEEF);
  endtask

  task automatic testAlign();
    logic [31:0] rd; logic er;
    regAcc(1, 4'h4, 32'h0, 4'h3, rd, er);
    check(er, "R2 byte-enable write err", {31'b0, er}, 1);
    regAcc(1, 4'h6, 32'h0, 4'hF, rd, er);
    check(er, "R2 offset write err", {31'b0, er}, 1);
    regAcc(0, 4'h1, 32'h0, 4'hF, rd, er);
    check(er && rd == 0, "R2 misaligned read", rd, 0);
    rd32(4'h4, rd);
    check(rd == 32'hA5A5_0F0F, "R2 mask unchanged", rd, 32'hA5A5_0F0F);
    regAcc(1, 4'hC, 32'h1, 4'h1, rd, er);
    rd32(4'hC, rd);
    check(rd == 0 && dmaReq == 0, "R2 rejected start", rd, 0);
  endtask

  task automatic testHappy();
    logic [31:0] rd;
    int r0 = readReqs, w0 = writeReqs;
    latency = 2;
    mem[0] = 32'hCAFE_BABE; mem[4] = 0;
    runXfer(32'h4000_0000, 32'h1234_5678, 32'h4000_0010);
    waitIrq("R8 irq after done");
    check(mem[4] == 32'hD8CA_ECC6, "R4 xor result", mem[4], 32'hD8CA_ECC6);
    check(readReqs - r0 == 1 && writeReqs - w0 == 1, "R4 one read one write",
          readReqs - r0, 1);
    rd32(4'hC, rd);
    check(rd == 32'h2, "R5 done only", rd, 32'h2);
    check(!addrMoved, "R11 address held", {31'b0, addrMoved}, 0);
    wr32(4'hC, 32'h0);
    rd32(4'hC, rd);
    check(rd == 32'h2 && irq, "R3 zero write keeps done", rd, 32'h2);
    wr32(4'hC, 32'h2);
    check(!irq, "R8 irq falls on clear", {31'b0, irq}, 0);
    rd32(4'hC, rd);
    check(rd == 0, "R3 done cleared", rd, 0);
  endtask

  task automatic testLaneOrder();
    mem[1] = 32'h1122_3344; mem[5] = 0;
    latency = 0;
    runXfer(32'h6000_0004, 32'hFF00_0000, 32'h4000_0014);
    waitIrq("R8 irq lane test");
    check(mem[5] == 32'hEE22_3344, "R4 mask msb hits addr+0", mem[5], 32'hEE22_3344);
    wr32(4'hC, 32'h2);
  endtask

  task automatic testBusy();
    logic [31:0] rd;
    int r0, w0;
    mem[2] = 32'h00FF_00FF; mem[6] = 0;
    latency = 6;
    r0 = readReqs; w0 = writeReqs;
    runXfer(32'h4000_0008, 32'hA5A5_A5A5, 32'h4000_0018);
    rd32(4'hC, rd);
    check(rd == 32'h1, "R9 start reads 1 while busy", rd, 1);
    wr32(4'h4, 32'h0);          // rewrite mask mid-transfer (R4 captured operand)
    wr32(4'hC, 32'h1);          // ignored start
    waitIrq("R8 irq busy test");
    repeat (20) @(negedge clk);
    check(readReqs - r0 == 1 && writeReqs - w0 == 1, "R9 no second transfer",
          readReqs - r0 + writeReqs - w0, 2);
    check(mem[6] == 32'hA55A_A55A, "R4 captured mask", mem[6], 32'hA55A_A55A);
    wr32(4'hC, 32'h2);
  endtask

  task automatic testReadErr();
    logic [31:0] rd;
    int w0 = writeReqs;
    latency = 1;
    runXfer(32'hDEAD_0000, 32'h1, 32'h4000_0000);
    waitIrq("R8 irq on read error");
    repeat (4) @(negedge clk);
    rd32(4'hC, rd);
    check(rd == 32'h4, "R6 error set done clear", rd, 4);
    check(writeReqs == w0, "R6 no write after read error", writeReqs - w0, 0);
  endtask

  task automatic testStaleClear();
    logic [31:0] rd;
    mem[3] = 32'h0000_0001;
    latency = 4;
    runXfer(32'h4000_000C, 32'h0000_0003, 32'h4000_0004);
    rd32(4'hC, rd);
    check(rd == 32'h1 && !irq, "R10 stale error cleared", rd, 1);
    waitIrq("R8 irq after stale test");
    rd32(4'hC, rd);
    check(rd == 32'h2, "R10 done after restart", rd, 2);
    wr32(4'hC, 32'h2);
  endtask

  task automatic testWriteErr();
    logic [31:0] rd;
    latency = 0;
    runXfer(32'h4000_0000, 32'h0, 32'h6000_0000);
    waitIrq("R8 irq on write error");
    rd32(4'hC, rd);
    check(rd == 32'h4, "R7 write error flags", rd, 4);
    wr32(4'hC, 32'h4);
    check(!irq, "R8 irq falls on error clear", {31'b0, irq}, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testRegs();
    testAlign();
    testHappy();
    testLaneOrder();
    testBusy();
    testReadErr();
    testStaleClear();
    testWriteErr();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule